// File: doc/BRIEF.md
# Retention Latch Result Cache

This block keeps a few of the most recently produced results close to the issue stage. Issuing instructions can then pick up their source operands without the reorder buffer banks needing read ports for that purpose. Every result that appears on the forwarding path is captured, and the reorder buffer index of the producing instruction serves as its tag. The latches are filled in strict rotation, so the oldest allocation is the one that gets overwritten.

A consumer presents one index per read port and learns in the same cycle whether the value is held. If it is not held, the wait flag tells the consumer to keep waiting. The value will be driven again on the forwarding buses when its producer commits. Commit and pipeline flush remove entries, so an index that has been retired or squashed never produces a hit.

Top module: `retention_latch_cache`

## Requirements
- R1: A write (`wr_en_i`=1, no flush) of an index that is not resident is held from the next cycle on. A lookup of that index then hits and returns the written data.
- R2: Each read port p takes its index from bits [p*IDX_W +: IDX_W] of `rd_tag_i` and its data on bits [p*DATA_W +: DATA_W] of `rd_data_o`. The ports work independently and answer combinationally in the lookup cycle. On a requested port, wait equals not-hit. A port without a request shows hit=0, wait=0 and data 0, and a miss returns data 0.
- R3: A new allocation goes to the latch that was allocated longest ago, whether or not that latch is still valid. After ENTRIES further allocations, an index is no longer resident.
- R4: Writing an index that is already resident replaces its data in the same latch. No latch is consumed and no other entry moves closer to eviction.
- R5: When a lookup requests the index being written in the same cycle, it hits and returns the new data.
- R6: A flush empties every latch from the next cycle and discards a write made in the same cycle. After a flush, allocation restarts from a fresh rotation.
- R7: A commit (`cmt_en_i`) drops the entry holding that index from the next cycle. If the same index is written in the same cycle, the write takes precedence.
- R8: Commit and flush do not affect lookups made in the cycle in which they are signalled.
- R9: After reset no latch is valid, so every requested lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all latches |
| wr_en_i | input | 1 | Result present on forwarding path |
| wr_tag_i | input | IDX_W | Reorder buffer index of the result |
| wr_data_i | input | DATA_W | Result value |
| cmt_en_i | input | 1 | Producer commit strobe |
| cmt_tag_i | input | IDX_W | Index of the committing producer |
| rd_req_i | input | RD_PORTS | Lookup request per port |
| rd_tag_i | input | RD_PORTS*IDX_W | Lookup index per port |
| rd_hit_o | output | RD_PORTS | Value held (or bypassed) |
| rd_wait_o | output | RD_PORTS | Miss: wait for rebroadcast at commit |
| rd_data_o | output | RD_PORTS*DATA_W | Looked-up value per port |

## Verification
The bench builds two instances. The first uses ENTRIES=8 with two read ports, which brings simultaneous lookups of different indices and same-cycle bypass on either port within reach. The second uses ENTRIES=16 with one read port, which covers the single-port variant and eviction at the deeper end of the allowed range. In the random phase, indices are drawn from a range only slightly wider than the deepest set. This makes update-in-place, eviction, pointer wrap and commit of resident indices frequent events.

// File: rtl/rlat_pkg.sv
package rlat_pkg;

  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_FILL = 2'd1,
    SLOT_DROP = 2'd2
  } slot_op_e;

  // Rotation step for the allocation pointer.
  function automatic int wrap_next(input int cur, input int lim);
    return (cur + 1 >= lim) ? 0 : cur + 1;
  endfunction

  // Per-latch action: flush beats everything, a fill beats an invalidate.
  function automatic slot_op_e slot_next_op(input logic clr, input logic fill,
                                            input logic inval);
    if (clr)        return SLOT_DROP;
    else if (fill)  return SLOT_FILL;
    else if (inval) return SLOT_DROP;
    else            return SLOT_HOLD;
  endfunction

endpackage

// File: rtl/rlat_tag_match.sv
module rlat_tag_match #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 7
) (
  input  logic [ENTRIES-1:0]       vld_i,
  input  logic [ENTRIES*IDX_W-1:0] tags_i,
  input  logic [IDX_W-1:0]         key_i,
  output logic [ENTRIES-1:0]       hit_vec_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec_o[i] = vld_i[i] && (tags_i[i*IDX_W +: IDX_W] == key_i);
  end
endmodule

// File: rtl/rlat_fifo_ptr.sv
module rlat_fifo_ptr
  import rlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_o <= '0;
    else if (clear_i) ptr_o <= '0;
    else if (adv_i)   ptr_o <= PTR_W'(wrap_next(int'(ptr_o), ENTRIES));
  end
endmodule

// File: rtl/rlat_read_port.sv
module rlat_read_port #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 32
) (
  input  logic                      req_i,
  input  logic [IDX_W-1:0]          key_i,
  input  logic [ENTRIES-1:0]        vld_i,
  input  logic [ENTRIES*IDX_W-1:0]  tags_i,
  input  logic [ENTRIES*DATA_W-1:0] datas_i,
  input  logic                      byp_en_i,
  input  logic [IDX_W-1:0]          byp_tag_i,
  input  logic [DATA_W-1:0]         byp_data_i,
  output logic                      hit_o,
  output logic                      wait_o,
  output logic [DATA_W-1:0]         data_o
);
  logic [ENTRIES-1:0] lat_match;
  logic [DATA_W-1:0]  lat_data;
  logic               byp_hit;

  rlat_tag_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .vld_i    (vld_i),
    .tags_i   (tags_i),
    .key_i    (key_i),
    .hit_vec_o(lat_match)
  );

  assign byp_hit = byp_en_i && (byp_tag_i == key_i);

  // Tags are unique among valid latches, so an AND-OR mux suffices.
  always_comb begin
    lat_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lat_match[i]) lat_data = lat_data | datas_i[i*DATA_W +: DATA_W];
    end
  end

  assign hit_o  = req_i && (byp_hit || (|lat_match));
  assign wait_o = req_i && !hit_o;
  assign data_o = !req_i ? '0 : (byp_hit ? byp_data_i : lat_data);
endmodule

// File: rtl/retention_latch_cache.sv
module retention_latch_cache
  import rlat_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int IDX_W    = 7,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_tag_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         cmt_en_i,
  input  logic [IDX_W-1:0]             cmt_tag_i,
  input  logic [RD_PORTS-1:0]          rd_req_i,
  input  logic [RD_PORTS*IDX_W-1:0]    rd_tag_i,
  output logic [RD_PORTS-1:0]          rd_hit_o,
  output logic [RD_PORTS-1:0]          rd_wait_o,
  output logic [RD_PORTS*DATA_W-1:0]   rd_data_o
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Latch storage
  logic [ENTRIES-1:0]        vld_q;
  logic [IDX_W-1:0]          tag_q  [ENTRIES];
  logic [DATA_W-1:0]         data_q [ENTRIES];
  logic [ENTRIES*IDX_W-1:0]  tag_flat;
  logic [ENTRIES*DATA_W-1:0] data_flat;
  logic [PTR_W-1:0]          ptr_q;

  // Named internal events
  logic [ENTRIES-1:0] wr_match;
  logic [ENTRIES-1:0] cmt_match;
  logic [ENTRIES-1:0] fill_sel;
  logic               wr_resident;
  logic               ev_update;
  logic               ev_alloc;
  slot_op_e           slot_op [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign tag_flat[i*IDX_W +: IDX_W]    = tag_q[i];
    assign data_flat[i*DATA_W +: DATA_W] = data_q[i];
  end

  rlat_tag_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_wr_match (
    .vld_i(vld_q), .tags_i(tag_flat), .key_i(wr_tag_i), .hit_vec_o(wr_match)
  );

  rlat_tag_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cmt_match (
    .vld_i(vld_q), .tags_i(tag_flat), .key_i(cmt_tag_i), .hit_vec_o(cmt_match)
  );

  assign wr_resident = |wr_match;
  assign ev_update   = wr_en_i && !flush_i && wr_resident;
  assign ev_alloc    = wr_en_i && !flush_i && !wr_resident;

  always_comb begin
    if (ev_update)     fill_sel = wr_match;
    else if (ev_alloc) fill_sel = ENTRIES'(1) << ptr_q;
    else               fill_sel = '0;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      slot_op[i] = slot_next_op(flush_i, fill_sel[i], cmt_en_i && cmt_match[i]);
    end
  end

  rlat_fifo_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(flush_i),
    .adv_i  (ev_alloc),
    .ptr_o  (ptr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        case (slot_op[i])
          SLOT_FILL: vld_q[i] <= 1'b1;
          SLOT_DROP: vld_q[i] <= 1'b0;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (slot_op[i] == SLOT_FILL) begin
        tag_q[i]  <= wr_tag_i;
        data_q[i] <= wr_data_i;
      end
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    rlat_read_port #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rp (
      .req_i     (rd_req_i[p]),
      .key_i     (rd_tag_i[p*IDX_W +: IDX_W]),
      .vld_i     (vld_q),
      .tags_i    (tag_flat),
      .datas_i   (data_flat),
      .byp_en_i  (wr_en_i),
      .byp_tag_i (wr_tag_i),
      .byp_data_i(wr_data_i),
      .hit_o     (rd_hit_o[p]),
      .wait_o    (rd_wait_o[p]),
      .data_o    (rd_data_o[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/retention_latch_cache_chk.sv
module retention_latch_cache_chk #(
  parameter int ENTRIES  = 8,
  parameter int IDX_W    = 7,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2,
  localparam int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush_i,
  input logic                       wr_en_i,
  input logic [IDX_W-1:0]           wr_tag_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic                       cmt_en_i,
  input logic [IDX_W-1:0]           cmt_tag_i,
  input logic [RD_PORTS-1:0]        rd_req_i,
  input logic [RD_PORTS*IDX_W-1:0]  rd_tag_i,
  input logic [RD_PORTS-1:0]        rd_hit_o,
  input logic [RD_PORTS*DATA_W-1:0] rd_data_o,
  input logic [ENTRIES-1:0]         vld_q,
  input logic [ENTRIES*IDX_W-1:0]   tag_flat,
  input logic [PTR_W-1:0]           ptr_q,
  input logic                       ev_alloc,
  input logic [ENTRIES-1:0]         wr_match
);
  logic [IDX_W-1:0]   cmt_tag_q;
  logic [IDX_W-1:0]   wr_tag_q;
  logic [ENTRIES-1:0] stale_vec;
  logic [ENTRIES-1:0] present_vec;

  always_ff @(posedge clk) begin
    cmt_tag_q <= cmt_tag_i;
    wr_tag_q  <= wr_tag_i;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      stale_vec[i]   = vld_q[i] && (tag_flat[i*IDX_W +: IDX_W] == cmt_tag_q);
      present_vec[i] = vld_q[i] && (tag_flat[i*IDX_W +: IDX_W] == wr_tag_q);
    end
  end

  // R1: a write that is not flushed is resident afterwards
  p_fill_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !flush_i) |=> (|present_vec));

  // R3: each allocation moves the rotation by one latch
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> (ptr_q == PTR_W'((int'($past(ptr_q)) + 1) % ENTRIES)));

  // R4: never two latches with the written index; updates consume nothing
  p_unique_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> $onehot0(wr_match));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_alloc && !flush_i) |=> $stable(ptr_q));

  // R6: flush leaves nothing valid
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));

  // R7: committed index is gone unless rewritten in the same cycle
  p_commit_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_en_i && !flush_i && !(wr_en_i && (wr_tag_i == cmt_tag_i))) |=> (stale_vec == '0));

  // R5: same-cycle bypass on every port
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_byp
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && rd_req_i[p] && (rd_tag_i[p*IDX_W +: IDX_W] == wr_tag_i)) |->
      (rd_hit_o[p] && (rd_data_o[p*DATA_W +: DATA_W] == wr_data_i)));
  end
endmodule

bind retention_latch_cache retention_latch_cache_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W), .RD_PORTS(RD_PORTS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush_i  (flush_i),
  .wr_en_i  (wr_en_i),
  .wr_tag_i (wr_tag_i),
  .wr_data_i(wr_data_i),
  .cmt_en_i (cmt_en_i),
  .cmt_tag_i(cmt_tag_i),
  .rd_req_i (rd_req_i),
  .rd_tag_i (rd_tag_i),
  .rd_hit_o (rd_hit_o),
  .rd_data_o(rd_data_o),
  .vld_q    (vld_q),
  .tag_flat (tag_flat),
  .ptr_q    (ptr_q),
  .ev_alloc (ev_alloc),
  .wr_match (wr_match)
);

// File: tb/retention_latch_cache_tb_top.sv
`timescale 1ns/1ps

module rlat_bench_core #(
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2
) (
  input  logic clk,
  output logic done,
  output int   n_cmp,
  output int   n_bad
);
  localparam int IW = 7;
  localparam int DW = 32;

  logic                  rst_n;
  logic                  flush;
  logic                  wr_en;
  logic [IW-1:0]         wr_tag;
  logic [DW-1:0]         wr_data;
  logic                  cmt_en;
  logic [IW-1:0]         cmt_tag;
  logic [RD_PORTS-1:0]   rd_req;
  logic [RD_PORTS*IW-1:0] rd_tag;
  logic [RD_PORTS-1:0]   rd_hit;
  logic [RD_PORTS-1:0]   rd_wait;
  logic [RD_PORTS*DW-1:0] rd_data;

  retention_latch_cache #(
    .ENTRIES(ENTRIES), .IDX_W(IW), .DATA_W(DW), .RD_PORTS(RD_PORTS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .wr_en_i(wr_en), .wr_tag_i(wr_tag), .wr_data_i(wr_data),
    .cmt_en_i(cmt_en), .cmt_tag_i(cmt_tag),
    .rd_req_i(rd_req), .rd_tag_i(rd_tag),
    .rd_hit_o(rd_hit), .rd_wait_o(rd_wait), .rd_data_o(rd_data)
  );

  // Reference model: queue ordered by allocation age, oldest first.
  typedef struct {
    bit          alive;
    int          tag;
    logic [31:0] data;
  } ent_t;

  ent_t  ages[$];
  string cur_req;

  task automatic model_empty();
    ent_t e;
    ages.delete();
    e.alive = 0; e.tag = -1; e.data = '0;
    for (int i = 0; i < ENTRIES; i++) ages.push_back(e);
  endtask

  task automatic clear_inputs();
    flush = 0; wr_en = 0; wr_tag = '0; wr_data = '0;
    cmt_en = 0; cmt_tag = '0; rd_req = '0; rd_tag = '0;
  endtask

  task automatic set_rd(input int p, input int t);
    rd_req[p] = 1'b1;
    rd_tag[p*IW +: IW] = IW'(t);
  endtask

  task automatic put(input int t, input logic [31:0] d);
    wr_en = 1'b1; wr_tag = IW'(t); wr_data = d;
  endtask

  task automatic check_outputs();
    for (int p = 0; p < RD_PORTS; p++) begin
      bit          eh, ew, byp;
      logic [31:0] ed;
      int          t;
      string       lbl;
      t = int'(rd_tag[p*IW +: IW]);
      eh = 0; ew = 0; ed = '0; byp = 0;
      if (rd_req[p]) begin
        if (wr_en && int'(wr_tag) == t) begin
          eh = 1; ed = wr_data; byp = 1;
        end else begin
          foreach (ages[k]) if (ages[k].alive && ages[k].tag == t) begin
            eh = 1; ed = ages[k].data;
          end
        end
        ew = !eh;
      end
      lbl = byp ? "R5" : cur_req;
      n_cmp++;
      if (rd_hit[p] !== eh || rd_wait[p] !== ew || rd_data[p*DW +: DW] !== ed) begin
        n_bad++;
        $display("FAIL %s E=%0d port %0d tag %0d: hit=%0b wait=%0b data=%h expected hit=%0b wait=%0b data=%h",
                 lbl, ENTRIES, p, t, rd_hit[p], rd_wait[p], rd_data[p*DW +: DW], eh, ew, ed);
      end
    end
  endtask

  task automatic model_update();
    if (!rst_n) begin
      model_empty();
    end else if (flush) begin
      model_empty();
    end else begin
      if (wr_en) begin
        bit found;
        found = 0;
        foreach (ages[k]) if (ages[k].alive && ages[k].tag == int'(wr_tag)) begin
          ages[k].data = wr_data; found = 1;
        end
        if (!found) begin
          ent_t e;
          e.alive = 1; e.tag = int'(wr_tag); e.data = wr_data;
          void'(ages.pop_front());
          ages.push_back(e);
        end
      end
      if (cmt_en && !(wr_en && wr_tag == cmt_tag)) begin
        foreach (ages[k]) if (ages[k].tag == int'(cmt_tag)) ages[k].alive = 0;
      end
    end
  endtask

  task automatic step();
    #1;
    check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  initial begin
    done = 0; n_cmp = 0; n_bad = 0;
    model_empty();
    clear_inputs();
    rst_n = 0;
    @(negedge clk);
    // R9: reset state, lookups miss
    cur_req = "R9";
    for (int p = 0; p < RD_PORTS; p++) set_rd(p, p + 3);
    step(); step();
    rst_n = 1;
    step();

    // R1: fill then hit
    cur_req = "R1";
    clear_inputs(); put(5, 32'hA000_0005); step();
    clear_inputs(); set_rd(0, 5);
    if (RD_PORTS > 1) set_rd(1, 6);
    step();

    // R5: same-cycle bypass
    clear_inputs(); put(9, 32'hB000_0009); set_rd(0, 9);
    if (RD_PORTS > 1) set_rd(1, 9);
    step();

    // R4: update in place consumes no latch
    cur_req = "R4";
    clear_inputs(); put(5, 32'hC000_0005); step();
    for (int i = 0; i < ENTRIES - 2; i++) begin
      clear_inputs(); put(40 + i, 32'hD000_0000 + i); step();
    end
    clear_inputs(); set_rd(0, 5);
    if (RD_PORTS > 1) set_rd(1, 9);
    step();
    clear_inputs(); set_rd(0, 9); step();

    // R3: oldest allocation evicted first
    cur_req = "R3";
    clear_inputs(); put(60, 32'hE000_0060); step();
    clear_inputs(); set_rd(0, 5);
    if (RD_PORTS > 1) set_rd(1, 9);
    step();
    clear_inputs(); put(61, 32'hE000_0061); step();
    clear_inputs(); set_rd(0, 9); step();

    // R8: commit does not affect same-cycle lookup
    cur_req = "R8";
    clear_inputs(); cmt_en = 1; cmt_tag = 7'd40; set_rd(0, 40); step();
    // R7: committed index then misses
    cur_req = "R7";
    clear_inputs(); set_rd(0, 40); step();
    clear_inputs(); put(41, 32'hF000_0041); cmt_en = 1; cmt_tag = 7'd41; step();
    clear_inputs(); set_rd(0, 41); step();

    // R6: flush empties, same-cycle write dropped
    cur_req = "R8";
    clear_inputs(); flush = 1; put(70, 32'h7070_7070); set_rd(0, 41); step();
    cur_req = "R6";
    clear_inputs(); set_rd(0, 70);
    if (RD_PORTS > 1) set_rd(1, 41);
    step();
    clear_inputs(); put(71, 32'h7171_7171); step();
    clear_inputs(); set_rd(0, 71); step();

    // R2: random mixture
    cur_req = "R2";
    for (int c = 0; c < 3000; c++) begin
      clear_inputs();
      if ($urandom_range(0, 9) < 6) put(int'($urandom_range(0, 23)), $urandom);
      if ($urandom_range(0, 9) < 2) begin
        cmt_en = 1; cmt_tag = IW'($urandom_range(0, 23));
      end
      if ($urandom_range(0, 99) < 2) flush = 1;
      for (int p = 0; p < RD_PORTS; p++)
        if ($urandom_range(0, 9) < 8) set_rd(p, int'($urandom_range(0, 23)));
      step();
    end
    done = 1;
  end
endmodule

module retention_latch_cache_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic a_done, b_done;
  int   a_cmp, a_bad, b_cmp, b_bad;

  rlat_bench_core #(.ENTRIES(8),  .RD_PORTS(2)) u_core_a (
    .clk(clk), .done(a_done), .n_cmp(a_cmp), .n_bad(a_bad));
  rlat_bench_core #(.ENTRIES(16), .RD_PORTS(1)) u_core_b (
    .clk(clk), .done(b_done), .n_cmp(b_cmp), .n_bad(b_bad));

  initial begin
    int cycles;
    int bad;
    cycles = 0;
    while (!(a_done === 1'b1 && b_done === 1'b1) && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad = a_bad + b_bad;
    if (!(a_done === 1'b1 && b_done === 1'b1)) begin
      bad++;
      $display("FAIL R2 watchdog: ran %0d cycles, expected completion before 100000", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", a_cmp + b_cmp, bad);
    $finish;
  end
endmodule